// File: doc/BRIEF.md
# Unary Tape Adder

This block is a small Turing machine in hardware. A 32-square tape lives in flip-flops, with one bit per square: 0 is blank and 1 is a mark. A head pointer selects one square. A four-state control fixed to a single program adds two unary numbers. The caller writes the tape through a parallel load port. The tape holds a blank at square 0, then n1 marks, one blank, and n2 marks. The caller then pulses start.

The machine performs one transition per clock. A transition either writes one square or moves the head one square, and it may also change state. The program runs in four phases:
- It moves right across the first run.
- It fills the separating blank.
- It walks back to square 0.
- It erases the leftmost mark.

When the program halts, the tape holds n1+n2 contiguous marks and the done flag is raised. The tape and head stay readable on the output ports.

The machine stops with a fault flag in two cases. The first is a move past either end of the tape. The second is a (state, symbol) pair that the program does not define.

Top module: `unary_tape_adder`

## Requirements
- R1: After reset, busy, done and fault are 0, the tape output is all blank and the head is at square 0.
- R2: While not busy, a load pulse copies load_tape to the tape on the next clock (bit i is square i), puts the head on square 0 and clears done and fault.
- R3: While not busy, a start pulse makes busy 1 on the next clock with the head on square 0 in the initial state.
- R4: For a tape loaded as square 0 blank, squares 1..n1 marked, square n1+1 blank and squares n1+2..n1+n2+1 marked, the halted tape has squares 2..n1+n2+1 marked and every other square blank.
- R5: The run takes exactly 2*n1+6 clocks: done is first 1 after that many rising edges following the edge that accepted start.
- R6: After a halt, done stays 1, busy stays 0, and tape and head are stable until the next load or start.
- R7: Each busy clock changes either exactly one tape square or the head position by one, never both, unless that clock ends the run.
- R8: A move beyond the last square or before square 0 stops the run with fault 1 and done 0, and leaves the tape and head unchanged.
- R9: Reading a mark in the initial state, which is an undefined pair, stops the run at once with fault 1 and the tape unchanged.
- R10: Load and start are ignored while busy: the run completes on the tape that was loaded before it, with unchanged timing.
- R11: Load and start asserted in the same idle cycle load the new tape and begin a run on it.
- R12: busy, done and fault are never 1 at the same time (at most one of them is set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Parallel tape write strobe (accepted when idle) |
| load_tape | input | TAPE_LEN | Tape image, bit i = square i, 1 = mark |
| start | input | 1 | Begin a run (accepted when idle) |
| busy | output | 1 | Machine is stepping |
| done | output | 1 | Program halted normally |
| fault | output | 1 | Run stopped on a bound or undefined pair |
| tape | output | TAPE_LEN | Current tape contents |
| head | output | $clog2(TAPE_LEN) | Current head square |

## Verification
A load and a start can arrive in the same idle cycle. The bench pulses both together with a fresh operand pair. It judges the outcome by the halted tape and by a step count that matches the new first operand, not the old one.

A second collision is a load or start that arrives while a step is already executing. The bench provokes it one cycle into a run and confirms that the result and the 2*n1+6 cycle count both belong to the original tape.

// File: rtl/unary_tape_adder.sv
module unary_tape_adder #(
  parameter int TAPE_LEN = 32,
  localparam int HW = $clog2(TAPE_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [TAPE_LEN-1:0] load_tape,
  input  logic                start,
  output logic                busy,
  output logic                done,
  output logic                fault,
  output logic [TAPE_LEN-1:0] tape,
  output logic [HW-1:0]       head
);
  localparam logic [1:0] ST_SEEK = 2'd0, ST_RUN1 = 2'd1, ST_BACK = 2'd2, ST_TRIM = 2'd3;

  logic [TAPE_LEN-1:0] tape_r;
  logic [HW-1:0]       head_r;
  logic [1:0]          st, nxt;
  logic                run, done_r, fault_r;
  logic                go_r, go_l, wr, wv, halt, bad;

  wire sym    = tape_r[head_r];
  wire at_end = head_r == HW'(TAPE_LEN - 1);
  wire at_org = head_r == '0;
  wire off    = (go_r && at_end) || (go_l && at_org);

  always_comb begin
    go_r = 1'b0; go_l = 1'b0; wr = 1'b0; wv = 1'b0;
    halt = 1'b0; bad = 1'b0; nxt = st;
    case (st)
      ST_SEEK: if (!sym) begin go_r = 1'b1; nxt = ST_RUN1; end
               else bad = 1'b1;
      ST_RUN1: if (sym) go_r = 1'b1;
               else begin wr = 1'b1; wv = 1'b1; nxt = ST_BACK; end
      ST_BACK: if (sym) go_l = 1'b1;
               else begin go_r = 1'b1; nxt = ST_TRIM; end
      default: if (sym) begin wr = 1'b1; wv = 1'b0; end
               else halt = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tape_r <= '0; head_r <= '0; st <= ST_SEEK;
      run <= 1'b0; done_r <= 1'b0; fault_r <= 1'b0;
    end else if (run) begin
      if (bad || off) begin
        run <= 1'b0; fault_r <= 1'b1;
      end else if (halt) begin
        run <= 1'b0; done_r <= 1'b1;
      end else begin
        if (wr)   tape_r[head_r] <= wv;
        if (go_r) head_r <= head_r + 1'b1;
        if (go_l) head_r <= head_r - 1'b1;
        st <= nxt;
      end
    end else if (load || start) begin
      if (load) tape_r <= load_tape;
      head_r <= '0; st <= ST_SEEK;
      done_r <= 1'b0; fault_r <= 1'b0;
      run <= start;
    end
  end

  assign busy  = run;
  assign done  = done_r;
  assign fault = fault_r;
  assign tape  = tape_r;
  assign head  = head_r;
endmodule

// File: rtl/unary_tape_adder_chk.sv
module unary_tape_adder_chk #(
  parameter int TAPE_LEN = 32,
  localparam int HW = $clog2(TAPE_LEN)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                load,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                fault,
  input logic [TAPE_LEN-1:0] tape,
  input logic [HW-1:0]       head
);
  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done || fault ||
      (($countones(tape ^ $past(tape)) == 1) != (head != $past(head))));

  // R7
  single_square_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $countones(tape ^ $past(tape)) <= 1);

  // R6
  hold_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load && !start) |=> done && !busy && $stable(tape) && $stable(head));

  // R3
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy && head == '0);

  // R8
  fault_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fault) ##1 fault |-> $stable(tape) && $stable(head));

  // R12
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, fault}));
endmodule

bind unary_tape_adder unary_tape_adder_chk #(.TAPE_LEN(TAPE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .start(start), .busy(busy),
  .done(done), .fault(fault), .tape(tape), .head(head)
);

// File: tb/sim_unary_tape_adder.sv
module sim_unary_tape_adder;
  localparam int TL = 32;
  localparam int HW = $clog2(TL);

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, start = 1'b0;
  logic [TL-1:0] load_tape = '0;
  logic busy, done, fault;
  logic [TL-1:0] tape;
  logic [HW-1:0] head;
  int total = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  unary_tape_adder #(.TAPE_LEN(TL)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .load_tape(load_tape), .start(start),
    .busy(busy), .done(done), .fault(fault), .tape(tape), .head(head)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TL-1:0] run_of(input int n, input int at);
    logic [63:0] v = ((64'd1 << n) - 64'd1) << at;
    return v[TL-1:0];
  endfunction

  function automatic logic [TL-1:0] operands(input int n1, input int n2);
    return run_of(n1, 1) | run_of(n2, n1 + 2);
  endfunction

  task automatic wait_end(output int k);
    k = 0;
    while (!done && !fault && k < 300) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 fault", fault, 0);
    chk("R1 tape", tape, 0); chk("R1 head", head, 0);
  endtask

  task automatic t_add(input int n1, input int n2);
    int k;
    load = 1'b1; load_tape = operands(n1, n2);
    @(negedge clk); load = 1'b0;
    chk("R2 tape", tape, operands(n1, n2)); chk("R2 head", head, 0);
    chk("R2 flags", {busy, done, fault}, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R3 busy", busy, 1); chk("R3 head", head, 0);
    wait_end(k);
    chk("R5 cycles", k, 2 * n1 + 6);
    chk("R4 tape", tape, run_of(n1 + n2, 2));
    chk("R4 done", done, 1);
    for (int i = 0; i < 3; i++) begin
      logic [TL-1:0] t0 = tape;
      logic [HW-1:0] h0 = head;
      @(negedge clk);
      chk("R6 hold", {done, busy, tape, head}, {1'b1, 1'b0, t0, h0});
    end
  endtask

  task automatic t_right_edge;
    int k;
    load = 1'b1; load_tape = run_of(TL - 1, 1);
    start = 1'b1; @(negedge clk); load = 1'b0; start = 1'b0;
    wait_end(k);
    chk("R8 fault", fault, 1); chk("R8 done", done, 0); chk("R8 busy", busy, 0);
    chk("R8 tape", tape, run_of(TL - 1, 1)); chk("R8 head", head, TL - 1);
  endtask

  task automatic t_undefined;
    load = 1'b1; load_tape = 32'h0000_0005;
    @(negedge clk); load = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk("R9 fault", fault, 1); chk("R9 tape", tape, 32'h0000_0005);
    chk("R9 head", head, 0);
  endtask

  task automatic t_ignore_busy;
    int k;
    load = 1'b1; load_tape = operands(2, 2);
    @(negedge clk); load = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    @(negedge clk);
    load = 1'b1; start = 1'b1; load_tape = operands(7, 1);
    @(negedge clk); load = 1'b0; start = 1'b0;
    wait_end(k);
    chk("R10 cycles", k + 2, 2 * 2 + 6);
    chk("R10 tape", tape, run_of(4, 2));
  endtask

  task automatic t_load_and_start;
    int k;
    load = 1'b1; start = 1'b1; load_tape = operands(4, 1);
    @(negedge clk); load = 1'b0; start = 1'b0;
    chk("R11 busy", busy, 1);
    wait_end(k);
    chk("R11 cycles", k, 2 * 4 + 6);
    chk("R11 tape", tape, run_of(5, 2));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add(3, 4);
    t_add(0, 3);
    t_add(1, 0);
    t_add(0, 0);
    t_add(10, 19);
    t_right_edge();
    t_undefined();
    t_ignore_busy();
    t_load_and_start();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule